// File: doc/BRIEF.md
# Debug Register Access Unit

This block holds eight debug registers and serves single move-to and move-from requests against them. Each request carries a 3-bit register index, a direction, write data, the current privilege level, the processor mode and the debug-extension enable. The block first classifies the request against the access rules in a fixed priority order. When no fault applies, it performs the read or write. It always answers exactly one cycle later, either with read data or with a fault class.

When the extension enable is clear, indices 4 and 5 are aliases of registers 6 and 7. When it is set, those two indices are illegal. Bit 13 of register 7 is the general-detect flag. While it is set, every access is trapped. Outside 64-bit mode the operands are 32 bits wide. Breakpoint matching and status reporting are handled elsewhere.

Top module: `dbgreg_unit`

## Requirements
- R1: After reset, rsp_valid_o is low and every register reads as zero.
- R2: Every cycle with req_i high produces exactly one response, with rsp_valid_o high on the following cycle. No other cycle produces a response.
- R3: In 64-bit mode (mode_i = 3) at CPL 0, a completed write stores all 64 bits. A later read of the same index returns that value with fault_o = 0.
- R4: With ext_en_i = 0, index 4 reads and writes register 6, and index 5 reads and writes register 7.
- R5: With ext_en_i = 1, any access to index 4 or 5 returns fault_o = 2 (invalid opcode).
- R6: In virtual-8086 mode (mode_i = 2), every access returns fault_o = 1 (general protection) at any CPL.
- R7: In protected mode (mode_i = 1) or 64-bit mode, a nonzero CPL returns fault_o = 1. In real mode (mode_i = 0), the access completes at any CPL.
- R8: While bit 13 of register 7 is set, any access that passes the checks of R5 to R7 returns fault_o = 3 (debug trap). This includes writes to register 7.
- R9: The checks have a fixed priority: the general-protection fault first, then the invalid opcode, then the debug trap.
- R10: A request that faults leaves every register unchanged.
- R11: Outside 64-bit mode, a write stores the low 32 bits of the write data and clears the upper 32 bits. A read returns the low 32 bits with the upper 32 bits zero.
- R12: rdata_o is zero on every response that is not a completed read. This covers faults and write completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one per cycle |
| wr_i | input | 1 | 1 = write to a debug register, 0 = read |
| idx_i | input | 3 | Debug register index |
| wdata_i | input | 64 | Write data |
| cpl_i | input | 2 | Current privilege level |
| mode_i | input | 2 | 0 real, 1 protected, 2 virtual-8086, 3 64-bit |
| ext_en_i | input | 1 | Debug-extension enable |
| rsp_valid_o | output | 1 | Response valid, one cycle after req_i |
| fault_o | output | 2 | 0 done, 1 general protection, 2 invalid opcode, 3 debug trap |
| rdata_o | output | 64 | Read data |

## Verification
Every result is due one cycle after its request. The fault class and the read data both appear on the edge after req_i is sampled. A completed write takes effect at the edge that samples it, so a request in the next cycle already sees the new value.

The bench drives each request on a falling edge and pushes its expected fault and data onto a queue in the same step. The monitor pops one item for each rsp_valid_o it sees on the next falling edge. A response with nothing expected, or an item still queued at the end, counts as a failure. Back-to-back requests are mixed with idle gaps, so the queue tests the exact one-cycle spacing.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2,
    FLT_DB   = 2'd3
  } fault_e;

  localparam int unsigned IDX_W     = 3;
  localparam int unsigned ALIAS_LO  = 4;
  localparam int unsigned ALIAS_HI  = 5;
  localparam int unsigned TARGET_LO = 6;
  localparam int unsigned TARGET_HI = 7;
  localparam int unsigned CTRL_IDX  = 7;
endpackage

// File: rtl/dbgreg_check.sv
module dbgreg_check
  import dbgreg_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ext_en_i,
  input  logic [1:0]       cpl_i,
  input  cpu_mode_e        mode_i,
  input  logic             gd_i,
  output fault_e           fault_o,
  output logic [IDX_W-1:0] phys_idx_o
);
  logic is_alias;
  logic priv_bad;

  assign is_alias = (idx_i == IDX_W'(ALIAS_LO)) || (idx_i == IDX_W'(ALIAS_HI));
  assign priv_bad = (mode_i == MODE_V86) || ((mode_i != MODE_REAL) && (cpl_i != 2'd0));

  always_comb begin
    phys_idx_o = idx_i;
    if (idx_i == IDX_W'(ALIAS_LO)) phys_idx_o = IDX_W'(TARGET_LO);
    else if (idx_i == IDX_W'(ALIAS_HI)) phys_idx_o = IDX_W'(TARGET_HI);
  end

  // fixed priority: protection, illegal alias, general detect
  always_comb begin
    if (priv_bad)                  fault_o = FLT_GP;
    else if (ext_en_i && is_alias) fault_o = FLT_UD;
    else if (gd_i)                 fault_o = FLT_DB;
    else                           fault_o = FLT_NONE;
  end
endmodule

// File: rtl/dbgreg_size.sv
module dbgreg_size #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32
) (
  input  logic            wide_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] wdata_o,
  output logic [XLEN-1:0] rdata_o
);
  localparam int unsigned UPPER = XLEN - NARROW;

  generate
    if (XLEN > NARROW) begin : g_mask
      assign wdata_o = wide_i ? wdata_i : {{UPPER{1'b0}}, wdata_i[NARROW-1:0]};
      assign rdata_o = wide_i ? rdata_i : {{UPPER{1'b0}}, rdata_i[NARROW-1:0]};
    end else begin : g_pass
      logic unused_wide;
      assign unused_wide = wide_i;
      assign wdata_o = wdata_i;
      assign rdata_o = rdata_i;
    end
  endgenerate
endmodule

// File: rtl/dbgreg_file.sv
module dbgreg_file #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NREG   = 8,
  parameter int unsigned GD_BIT = 13,
  parameter int unsigned CTRL   = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [XLEN-1:0]         wdata_i,
  input  logic [$clog2(NREG)-1:0] raddr_i,
  output logic [XLEN-1:0]         rdata_o,
  output logic                    gd_o
);
  localparam int unsigned AW = $clog2(NREG);

  logic [NREG-1:0][XLEN-1:0] regs;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (we_i && (waddr_i == AW'(i)))    q <= wdata_i;
    end
    assign regs[i] = q;
  end

  assign rdata_o = regs[raddr_i];
  assign gd_o    = regs[CTRL][GD_BIT];

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs));
endmodule

// File: rtl/dbgreg_unit.sv
module dbgreg_unit
  import dbgreg_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32,
  parameter int unsigned NREG   = 8,
  parameter int unsigned GD_BIT = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [2:0]       idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [1:0]       cpl_i,
  input  logic [1:0]       mode_i,
  input  logic             ext_en_i,
  output logic             rsp_valid_o,
  output logic [1:0]       fault_o,
  output logic [XLEN-1:0]  rdata_o
);
  cpu_mode_e        mode;
  fault_e           fault;
  logic [IDX_W-1:0] phys_idx;
  logic             gd;
  logic             we;
  logic [XLEN-1:0]  wdata_sz, rdata_raw, rdata_sz;

  logic             rsp_valid_q;
  fault_e           fault_q;
  logic [XLEN-1:0]  rdata_q;

  assign mode = cpu_mode_e'(mode_i);

  dbgreg_check i_check (
    .idx_i      (idx_i),
    .ext_en_i   (ext_en_i),
    .cpl_i      (cpl_i),
    .mode_i     (mode),
    .gd_i       (gd),
    .fault_o    (fault),
    .phys_idx_o (phys_idx)
  );

  dbgreg_size #(.XLEN(XLEN), .NARROW(NARROW)) i_size (
    .wide_i  (mode == MODE_LONG),
    .wdata_i (wdata_i),
    .rdata_i (rdata_raw),
    .wdata_o (wdata_sz),
    .rdata_o (rdata_sz)
  );

  assign we = req_i && wr_i && (fault == FLT_NONE);

  dbgreg_file #(.XLEN(XLEN), .NREG(NREG), .GD_BIT(GD_BIT), .CTRL(CTRL_IDX)) i_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (phys_idx),
    .wdata_i (wdata_sz),
    .raddr_i (phys_idx),
    .rdata_o (rdata_raw),
    .gd_o    (gd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      fault_q     <= FLT_NONE;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= req_i;
      fault_q     <= req_i ? fault : FLT_NONE;
      rdata_q     <= (req_i && !wr_i && fault == FLT_NONE) ? rdata_sz : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign fault_o     = fault_q;
  assign rdata_o     = rdata_q;

  assert_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  assert_no_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  assert_v86_gp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'd2) |=> fault_o == 2'd1);
  assert_alias_ud_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'd0 && ext_en_i && (idx_i == 3'd4 || idx_i == 3'd5))
    |=> fault_o == 2'd2);
  assert_gd_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'd0 && gd && !(ext_en_i && idx_i[2:1] == 2'b10))
    |=> fault_o == 2'd3);
  assert_zero_data_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o != 2'd0) |-> rdata_o == '0);
  assert_narrow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i != 2'd3) |=> rdata_o[XLEN-1:NARROW] == '0);
endmodule

// File: tb/test_dbgreg_unit.sv
module test_dbgreg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, de = 1'b0;
  logic [2:0]  idx = '0;
  logic [63:0] wd = '0;
  logic [1:0]  cpl = '0, mode = '0;
  logic        rsp_valid;
  logic [1:0]  fault;
  logic [63:0] rdata;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [63:0] model [8];
  logic [1:0]  q_f[$];
  logic [63:0] q_d[$];
  string       q_t[$];

  always #5 clk = ~clk;

  dbgreg_unit i_dbgreg_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .idx_i(idx),
    .wdata_i(wd), .cpl_i(cpl), .mode_i(mode), .ext_en_i(de),
    .rsp_valid_o(rsp_valid), .fault_o(fault), .rdata_o(rdata));

  task automatic issue(input bit w, input int i, input logic [63:0] d,
                       input int c, input int m, input bit e, input string tag);
    int p;
    logic [1:0] f;
    logic [63:0] ed;
    p = (i == 4) ? 6 : (i == 5) ? 7 : i;
    if (m == 2 || (m != 0 && c != 0)) f = 2'd1;
    else if (e && (i == 4 || i == 5)) f = 2'd2;
    else if (model[7][13]) f = 2'd3;
    else f = 2'd0;
    ed = '0;
    if (f == 2'd0) begin
      if (w) model[p] = (m == 3) ? d : {32'h0, d[31:0]};
      else ed = (m == 3) ? model[p] : {32'h0, model[p][31:0]};
    end
    q_f.push_back(f); q_d.push_back(ed); q_t.push_back(tag);
    req = 1'b1; wr = w; idx = 3'(i); wd = d; cpl = 2'(c); mode = 2'(m); de = e;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      tests++;
      if (q_f.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected response fault=%0d expected none", fault);
      end else begin
        logic [1:0] ef; logic [63:0] edd; string t;
        ef = q_f.pop_front(); edd = q_d.pop_front(); t = q_t.pop_front();
        if (fault !== ef || rdata !== edd) begin
          fails++;
          $display("FAIL %s: fault=%0d data=%h expected fault=%0d data=%h", t, fault, rdata, ef, edd);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++; $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid);
    end
    // R1 reset contents, real mode, back to back
    for (int k = 0; k < 8; k++) issue(0, k, '0, 0, 0, 0, "R1");
    idle(2);
    // R3 full width round trip in 64-bit mode
    issue(1, 0, 64'h1234_5678_9abc_def0, 0, 3, 0, "R12");
    issue(0, 0, '0, 0, 3, 0, "R3");
    issue(1, 1, 64'hfedc_ba98_7654_3210, 0, 3, 1, "R3");
    idle(1);
    issue(1, 3, 64'h0000_0001_0000_0002, 0, 3, 0, "R3");
    issue(0, 1, '0, 0, 3, 1, "R3");
    issue(0, 3, '0, 0, 3, 0, "R3");
    // R4 aliasing with extensions off
    issue(1, 4, 64'h0000_0000_0000_4ff0, 0, 3, 0, "R4");
    issue(0, 6, '0, 0, 3, 0, "R4");
    issue(1, 5, 64'h0000_0000_0000_0401, 0, 0, 0, "R4");
    issue(0, 7, '0, 0, 3, 0, "R4");
    issue(1, 6, 64'h0000_0000_0000_0aa5, 0, 3, 0, "R4");
    issue(0, 4, '0, 0, 3, 0, "R4");
    // R5 illegal alias, R10 nothing written
    issue(0, 4, '0, 0, 3, 1, "R5");
    issue(1, 5, 64'h0000_0000_0000_2000, 0, 0, 1, "R5");
    issue(0, 7, '0, 0, 3, 1, "R10");
    // R6 virtual-8086
    issue(0, 0, '0, 0, 2, 0, "R6");
    issue(1, 0, 64'h5555, 3, 2, 0, "R6");
    issue(0, 0, '0, 0, 3, 0, "R10");
    // R7 privilege
    issue(0, 1, '0, 3, 1, 0, "R7");
    issue(1, 1, 64'h77, 1, 3, 0, "R7");
    issue(0, 1, '0, 3, 0, 0, "R7");
    issue(0, 1, '0, 0, 3, 0, "R10");
    // R11 narrow operands
    issue(1, 2, 64'hffff_ffff_1111_2222, 0, 1, 0, "R11");
    issue(0, 2, '0, 0, 3, 0, "R11");
    issue(1, 2, 64'haaaa_bbbb_cccc_dddd, 0, 3, 0, "R11");
    issue(0, 2, '0, 0, 1, 0, "R11");
    issue(0, 2, '0, 0, 3, 0, "R11");
    // R9 priority before the trap is armed
    issue(0, 4, '0, 3, 1, 1, "R9");
    // R8 arm general detect
    issue(1, 7, 64'h0000_0000_0000_2000, 0, 3, 0, "R8");
    issue(0, 0, '0, 0, 3, 0, "R8");
    issue(1, 7, 64'h0, 0, 0, 0, "R8");
    issue(0, 5, '0, 0, 0, 0, "R8");
    issue(0, 4, '0, 0, 3, 1, "R9");
    issue(0, 2, '0, 0, 2, 0, "R9");
    issue(0, 3, '0, 2, 1, 1, "R9");
    idle(3);
    tests++;
    if (q_f.size() != 0) begin
      fails++; $display("FAIL R2: %0d responses missing, expected 0", q_f.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule